// File: doc/BRIEF.md
# Playback Blank Skip Detector

This block watches two audio channels during normal playback and reports when a pause in the music has been found. Each accepted sample pair is compared, channel by channel, against that channel's own DC reference raised by a common programmable offset. A saturating digital integrator climbs while both channels stay quiet. It is pulled down whenever either channel is louder than its threshold, and it falls faster when both are. A comparator with separate set and clear thresholds turns the integrator level into a stable pause/music flag.

Samples arrive on a valid/ready stream. The block takes one sample pair per cycle with no stalls while it is enabled, so `s_ready` is high in every enabled cycle after reset. While the block is disabled, `s_ready` is low and the upstream source has to hold its data. The detector is enabled only by one code of the two-bit search-mode input. Every other code clears the detector to the music state. A host watching `pause_found` is expected to filter short spikes itself.

Top module: `blank_skip_detector`

## Requirements
- R1: A channel counts as loud for a sample only when its level is strictly greater than its DC reference plus `level_ofs`. The comparison uses unsigned arithmetic wide enough that the sum never wraps, so a level equal to that sum counts as quiet.
- R2: Each accepted sample in which one or more channels are loud lowers the integrator by DISCHARGE_STEP (default 5) times the number of loud channels. The integrator stops at 0.
- R3: Each accepted sample in which neither channel is loud raises the integrator by CHARGE_STEP (default 1). The integrator stops at full scale, 2**INTEG_W-1 (default 255).
- R4: `pause_found` becomes 1 once the integrator is at or above UPPER (default 200). It becomes 0 once the integrator is at or below LOWER (default 40). Between the two it keeps its value.
- R5: The detector is enabled only when `mode_sel` equals 2'b01. The codes 2'b00, 2'b10 and 2'b11 disable it.
- R6: On the clock edge after the block becomes disabled, the integrator, both loud flags and `pause_found` clear to 0. They stay at 0 while the block is disabled.
- R7: A sample is consumed only on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high exactly when the block is enabled and out of reset. Cycles without a transfer leave the integrator unchanged.
- R8: The bits of `status` are: [INTEG_W-1:0] the integrator value; [INTEG_W] the loud flag of channel B; [INTEG_W+1] the loud flag of channel A; [INTEG_W+2] the enable state. Each loud flag holds the result for the last consumed sample.
- R9: Latency. A sample consumed at clock edge k updates the loud flags at edge k, the integrator at edge k+1, and `pause_found` at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Search-mode code; 2'b01 enables the detector |
| level_ofs | input | OFFSET_W | Threshold offset added to each DC reference |
| s_valid | input | 1 | A sample pair is present |
| s_ready | output | 1 | The block accepts a sample pair this cycle |
| s_level_a | input | SAMPLE_W | Rectified level, channel A |
| s_level_b | input | SAMPLE_W | Rectified level, channel B |
| dc_ref_a | input | SAMPLE_W | DC reference, channel A |
| dc_ref_b | input | SAMPLE_W | DC reference, channel B |
| pause_found | output | 1 | 1 = pause found, 0 = music found |
| status | output | INTEG_W+3 | Enable state, loud flags and integrator value |

## Verification
The hardest situations to reach from the ports are the exact edges of the hysteresis band. These are an integrator value landing exactly on UPPER or on LOWER, and a value inside the band after the flag has already flipped. The stimulus reaches them by counting samples from a known integrator value. Runs of quiet samples add exactly one step each, and runs of single-channel or dual-channel loud samples remove a known amount. This lets the integrator be placed on 200, 40, 55 or 170, and the flag is checked at each of them. A level exactly equal to reference plus offset, and a sum that would overflow the sample width, are driven to check the strict comparison at its edge.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int NUM_CH = 2;
  localparam logic [1:0] MODE_BLANK_SKIP = 2'b01;

  typedef struct packed {
    logic enabled;
    logic loud_a;
    logic loud_b;
  } bsd_flags_t;
endpackage

// File: rtl/bsd_level_cmp.sv
module bsd_level_cmp #(
  parameter int SAMPLE_W = 12,
  parameter int OFFSET_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [SAMPLE_W-1:0] dc_ref,
  input  logic [OFFSET_W-1:0] ofs,
  output logic                loud
);
  localparam int SUM_W = ((SAMPLE_W > OFFSET_W) ? SAMPLE_W : OFFSET_W) + 1;

  logic [SUM_W-1:0] thresh;
  logic             above;

  always_comb begin
    thresh = SUM_W'(dc_ref) + SUM_W'(ofs);
    above  = SUM_W'(level) > thresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      loud <= 1'b0;
    else if (!en)    loud <= 1'b0;
    else if (take)   loud <= above;
  end

  // R1: a level not above its own reference can never be loud
  assert_quiet_at_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && level <= dc_ref) |=> !loud);
endmodule

// File: rtl/bsd_integrator.sv
module bsd_integrator #(
  parameter int INTEG_W        = 8,
  parameter int NUM_CH         = 2,
  parameter int CHARGE_STEP    = 1,
  parameter int DISCHARGE_STEP = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               upd,
  input  logic [NUM_CH-1:0]  hits,
  output logic [INTEG_W-1:0] integ
);
  localparam int EXT_W = INTEG_W + 8;
  localparam logic [EXT_W-1:0] FULL_X = EXT_W'((1 << INTEG_W) - 1);
  localparam logic [EXT_W-1:0] CH_X   = EXT_W'(CHARGE_STEP);
  localparam logic [EXT_W-1:0] DS_X   = EXT_W'(DISCHARGE_STEP);

  logic [EXT_W-1:0] nhit, cur_x, up_x, drop_x, nxt_x;

  always_comb begin
    nhit = '0;
    for (int c = 0; c < NUM_CH; c++) nhit = nhit + EXT_W'(hits[c]);
    cur_x  = EXT_W'(integ);
    up_x   = cur_x + CH_X;
    drop_x = nhit * DS_X;
    if (nhit == '0) nxt_x = (up_x > FULL_X) ? FULL_X : up_x;
    else            nxt_x = (cur_x < drop_x) ? '0 : cur_x - drop_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    integ <= '0;
    else if (!en)  integ <= '0;
    else if (upd)  integ <= nxt_x[INTEG_W-1:0];
  end

  // R3: quiet samples climb by one charge step below full scale
  assert_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd && hits == '0 && EXT_W'(integ) + CH_X <= FULL_X)
      |=> EXT_W'(integ) == EXT_W'($past(integ)) + CH_X);
  // R3: full scale is a ceiling
  assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd && hits == '0 && EXT_W'(integ) == FULL_X) |=> EXT_W'(integ) == FULL_X);
  // R2: a loud sample below one discharge step lands on zero
  assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd && hits != '0 && EXT_W'(integ) < DS_X) |=> integ == '0);
  // R7: no transfer, no movement
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !upd) |=> $stable(integ));
endmodule

// File: rtl/bsd_hyst_cmp.sv
module bsd_hyst_cmp #(
  parameter int INTEG_W = 8,
  parameter int UPPER   = 200,
  parameter int LOWER   = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [INTEG_W-1:0] level,
  output logic               pause
);
  localparam logic [INTEG_W-1:0] UP_T = INTEG_W'(UPPER);
  localparam logic [INTEG_W-1:0] LO_T = INTEG_W'(LOWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pause <= 1'b0;
    else if (!en)           pause <= 1'b0;
    else if (level >= UP_T) pause <= 1'b1;
    else if (level <= LO_T) pause <= 1'b0;
  end

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level >= UP_T) |=> pause);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level <= LO_T) |=> !pause);
  assert_band_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level > LO_T && level < UP_T) |=> pause == $past(pause));
endmodule

// File: rtl/blank_skip_detector.sv
module blank_skip_detector
  import bsd_pkg::*;
#(
  parameter int SAMPLE_W       = 12,
  parameter int OFFSET_W       = 8,
  parameter int INTEG_W        = 8,
  parameter int CHARGE_STEP    = 1,
  parameter int DISCHARGE_STEP = 5,
  parameter int UPPER          = 200,
  parameter int LOWER          = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic [OFFSET_W-1:0]  level_ofs,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [SAMPLE_W-1:0]  s_level_a,
  input  logic [SAMPLE_W-1:0]  s_level_b,
  input  logic [SAMPLE_W-1:0]  dc_ref_a,
  input  logic [SAMPLE_W-1:0]  dc_ref_b,
  output logic                 pause_found,
  output logic [INTEG_W+2:0]   status
);
  logic                en;
  logic                live_q;
  logic                take;
  logic                upd_q;
  logic [SAMPLE_W-1:0] lvl  [NUM_CH];
  logic [SAMPLE_W-1:0] dref [NUM_CH];
  logic [NUM_CH-1:0]   loud;
  logic [INTEG_W-1:0]  integ;
  bsd_flags_t          flags;

  assign en      = (mode_sel == MODE_BLANK_SKIP);
  assign s_ready = en && live_q;
  assign take    = s_valid && s_ready;

  assign lvl[0]  = s_level_a;
  assign lvl[1]  = s_level_b;
  assign dref[0] = dc_ref_a;
  assign dref[1] = dc_ref_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      upd_q  <= en && take;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    bsd_level_cmp #(.SAMPLE_W(SAMPLE_W), .OFFSET_W(OFFSET_W)) cmp_i (
      .clk(clk), .rst_n(rst_n), .en(en), .take(take),
      .level(lvl[ch]), .dc_ref(dref[ch]), .ofs(level_ofs), .loud(loud[ch])
    );
  end

  bsd_integrator #(
    .INTEG_W(INTEG_W), .NUM_CH(NUM_CH),
    .CHARGE_STEP(CHARGE_STEP), .DISCHARGE_STEP(DISCHARGE_STEP)
  ) integ_i (
    .clk(clk), .rst_n(rst_n), .en(en), .upd(upd_q), .hits(loud), .integ(integ)
  );

  bsd_hyst_cmp #(.INTEG_W(INTEG_W), .UPPER(UPPER), .LOWER(LOWER)) hyst_i (
    .clk(clk), .rst_n(rst_n), .en(en), .level(integ), .pause(pause_found)
  );

  always_comb begin
    flags.enabled = en;
    flags.loud_a  = loud[0];
    flags.loud_b  = loud[1];
    status        = {flags, integ};
  end

  // R6: disabling clears the whole detector on the next edge
  assert_disabled_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (integ == '0 && !pause_found && loud == '0));
  // R5: only the blank-skip code opens the input stream
  assert_closed_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b01) |-> !s_ready);
endmodule

// File: tb/blank_skip_detector_tb_top.sv
module blank_skip_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b01;
  logic [7:0]  level_ofs = 8'd10;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_level_a = 12'd0, s_level_b = 12'd0, dc_ref_a = 12'd0, dc_ref_b = 12'd0;
  logic        pause_found;
  logic [10:0] status;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  blank_skip_detector dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .level_ofs(level_ofs),
    .s_valid(s_valid), .s_ready(s_ready), .s_level_a(s_level_a), .s_level_b(s_level_b),
    .dc_ref_a(dc_ref_a), .dc_ref_b(dc_ref_b), .pause_found(pause_found), .status(status)
  );

  typedef struct packed {
    int         n;
    logic [11:0] la, lb, ra, rb;
    logic [7:0]  ofs;
    int         ei;
    logic       ep;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{100, 12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10, 100, 1'b0},
    '{120, 12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10, 220, 1'b1},
    '{ 60, 12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10, 255, 1'b1},
    '{ 20, 12'd1200, 12'd1200, 12'd1000, 12'd1000, 8'd10,  55, 1'b1},
    '{  5, 12'd1200, 12'd1200, 12'd1000, 12'd1000, 8'd10,   5, 1'b0},
    '{  3, 12'd1200, 12'd1005, 12'd1000, 12'd1000, 8'd10,   0, 1'b0},
    '{250, 12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10, 250, 1'b1},
    '{ 30, 12'd1005, 12'd1200, 12'd1000, 12'd1000, 8'd10, 100, 1'b1},
    '{ 12, 12'd1005, 12'd1200, 12'd1000, 12'd1000, 8'd10,  40, 1'b0},
    '{ 30, 12'd1010, 12'd1010, 12'd1000, 12'd1000, 8'd10,  70, 1'b0},
    '{ 10, 12'd1011, 12'd1005, 12'd1000, 12'd1000, 8'd10,  20, 1'b0},
    '{150, 12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10, 170, 1'b0},
    '{ 40, 12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10, 210, 1'b1},
    '{  5, 12'd4095, 12'd1005, 12'd4000, 12'd1000, 8'd200, 215, 1'b1},
    '{  4, 12'd1001, 12'd1000, 12'd1000, 12'd1000, 8'd0,  195, 1'b1},
    '{  2, 12'd1000, 12'd20,   12'd3000, 12'd0,    8'd10, 185, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_inputs(input logic [11:0] la, lb, ra, rb, input logic [7:0] ofs);
    s_level_a = la; s_level_b = lb; dc_ref_a = ra; dc_ref_b = rb; level_ofs = ofs;
  endtask

  // one transfer per valid pulse, with bubbles; then drain the pipeline
  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % 7 == 3) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1;
    end
    @(negedge clk);
    s_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset integrator", int'(status[7:0]), 0);
    check("R6 reset pause", int'(pause_found), 0);
    check("R7 ready after reset", int'(s_ready), 1);
    check("R8 reset flags", int'(status[10:8]), 3'b100);

    // table walk: R1 R2 R3 R4 R7
    for (int v = 0; v < 16; v++) begin
      set_inputs(VEC[v].la, VEC[v].lb, VEC[v].ra, VEC[v].rb, VEC[v].ofs);
      send(VEC[v].n);
      check($sformatf("R2/R3 integrator vec%0d", v), int'(status[7:0]), VEC[v].ei);
      check($sformatf("R4 pause vec%0d", v), int'(pause_found), int'(VEC[v].ep));
      if (v == 9)  check("R1 equal level is quiet flags", int'(status[9:8]), 0);
      if (v == 14) check("R8 flags a loud", int'(status[10:8]), 3'b110);
      if (v == 15) check("R8 flags b loud", int'(status[10:8]), 3'b101);
    end

    // R6: disable clears, and stays clear while samples are offered
    @(negedge clk);
    mode_sel = 2'b00;
    set_inputs(12'd1005, 12'd1005, 12'd1000, 12'd1000, 8'd10);
    @(negedge clk);
    check("R6 disabled integrator", int'(status[7:0]), 0);
    check("R6 disabled pause", int'(pause_found), 0);
    check("R5 code 00 ready", int'(s_ready), 0);
    s_valid = 1'b1;
    repeat (30) @(negedge clk);
    s_valid = 1'b0;
    check("R7 no transfer while disabled", int'(status[7:0]), 0);
    mode_sel = 2'b10;
    @(negedge clk);
    check("R5 code 10 ready", int'(s_ready), 0);
    check("R5 code 10 enable bit", int'(status[10]), 0);
    mode_sel = 2'b11;
    @(negedge clk);
    check("R5 code 11 ready", int'(s_ready), 0);
    mode_sel = 2'b01;
    @(negedge clk);
    check("R5 code 01 ready", int'(s_ready), 1);
    check("R6 re-enable starts at music", int'(status[7:0]), 0);

    // R9 latency and R4 exact upper edge
    send(199);
    check("R3 before upper", int'(status[7:0]), 199);
    check("R4 below upper", int'(pause_found), 0);
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R9 integrator not yet", int'(status[7:0]), 199);
    @(negedge clk);
    check("R9 integrator after two edges", int'(status[7:0]), 200);
    check("R9 pause not yet", int'(pause_found), 0);
    @(negedge clk);
    check("R4 pause at exactly upper", int'(pause_found), 1);

    // R4 exact lower edge, both channels loud
    set_inputs(12'd1200, 12'd1200, 12'd1000, 12'd1000, 8'd10);
    send(15);
    check("R2 dual discharge", int'(status[7:0]), 50);
    check("R4 inside band holds pause", int'(pause_found), 1);
    send(1);
    check("R2 at lower", int'(status[7:0]), 40);
    check("R4 clear at exactly lower", int'(pause_found), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule